// File: doc/BRIEF.md
# Mailbox Interrupt Status Aggregator

This block gathers the level conditions of a set of shared mailboxes into one interrupt status word and drives several shared interrupt lines from it. Each mailbox contributes two sources: one that holds while it has data waiting for the consumer (full) and one that holds while it has nothing waiting (empty). The empty sources fill the low byte of the status word and the full sources fill the next byte.

Every interrupt line has its own bank of enable bits. A line is high in any cycle in which at least one status bit that its bank enables is set. Nothing is latched: when a source drops, or software clears its enable bit, the line drops with it. Software reaches the enable banks, the raw status word and a read-only capability word through a word-addressed port. A read request returns its data one clock later. The capability word reports the unit counts of the surrounding mailbox unit as 4-bit fields.

Top module: `mbx_irq_agg`

## Requirements
- R1: The status word at word address 0xC1 (byte offset 0x304) holds the empty source of mailbox i at bit i and the full source of mailbox i at bit 8+i. It is the raw condition, independent of every enable bank.
- R2: Status bits for mailboxes at or above NUM_MBOX read as zero, and status bits 31:16 read as zero.
- R3: Enable bank k sits at word address 0x40+k (byte offset 0x100+4k), for k below NUM_LINES. A write stores the 16 data bits in the bank, and a read returns them in bits 15:0 with bits 31:16 zero. Every bank is zero after reset, and every interrupt line is low after reset.
- R4: irq_line[k] is high exactly when the status word AND bank k is nonzero. The line follows a change of the mailbox sources in the same cycle, without any register in the path.
- R5: A line stays high for as long as an enabled source holds. It drops in the first cycle after a write clears the enable bit of that source.
- R6: The capability word at word address 0xE0 (byte offset 0x380) returns the mailbox count in bits 3:0, the shared semaphore count in bits 7:4, the arbitrated semaphore count in bits 11:8, the doorbell count in bits 15:12 and the shared interrupt line count in bits 19:16. All other bits are zero.
- R7: Writes to the status word, to the capability word, or to any address that does not decode to a bank change no stored state. Reads of addresses that do not decode return zero.
- R8: A read request (reg_valid high, reg_write low) produces rd_valid high with its data in the following cycle. The data is sampled when the request is taken. A write request does not raise rd_valid.
- R9: A write to one enable bank leaves every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mb_full | input | NUM_MBOX | Per-mailbox full level condition |
| mb_empty | input | NUM_MBOX | Per-mailbox empty level condition |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_waddr | input | 10 | Word address (byte offset divided by 4) |
| reg_wdata | input | 16 | Write data (enable bits) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_line | output | NUM_LINES | Shared level interrupt lines |

## Verification
A corrupted enable bank shows up at once as a wrong level on its interrupt line in the next cycle that an affected source holds. It also appears one cycle after a read of that bank. Corrupted decoding of the status word shows in the same cycle on any line that enables the misplaced bit. A reference model tracks the banks from the writes it issues and compares every line on every clock while the full and empty sources are driven in several patterns. This catches stray or late changes within one cycle.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    localparam int unsigned SRC_HALF   = 8;
    localparam int unsigned SRC_W      = 2 * SRC_HALF;
    localparam int unsigned WADDR_W    = 10;

    localparam logic [WADDR_W-1:0] BANK_BASE_W  = 10'h040;
    localparam logic [WADDR_W-1:0] STATUS_W_ADR = 10'h0C1;
    localparam logic [WADDR_W-1:0] CAP_W_ADR    = 10'h0E0;

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } rd_state_t;

    function automatic logic [31:0] cap_word(input int unsigned n_mbox,
                                             input int unsigned n_ss,
                                             input int unsigned n_as,
                                             input int unsigned n_db,
                                             input int unsigned n_line);
        logic [31:0] w;
        w        = '0;
        w[3:0]   = n_mbox[3:0];
        w[7:4]   = n_ss[3:0];
        w[11:8]  = n_as[3:0];
        w[15:12] = n_db[3:0];
        w[19:16] = n_line[3:0];
        return w;
    endfunction

    function automatic logic [31:0] status_mask(input int unsigned n_mbox);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < SRC_HALF; i++) begin
            if (i < n_mbox) begin
                m[i]            = 1'b1;
                m[SRC_HALF + i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/mbx_irq_status_pack.sv
module mbx_irq_status_pack #(
    parameter int unsigned NUM_MBOX = 6
) (
    input  logic [NUM_MBOX-1:0]           full,
    input  logic [NUM_MBOX-1:0]           empty,
    output logic [mbx_irq_pkg::SRC_W-1:0] status
);
    import mbx_irq_pkg::*;

    for (genvar i = 0; i < SRC_HALF; i++) begin : g_slot
        if (i < NUM_MBOX) begin : g_live
            assign status[i]            = empty[i];
            assign status[SRC_HALF + i] = full[i];
        end else begin : g_absent
            assign status[i]            = 1'b0;
            assign status[SRC_HALF + i] = 1'b0;
        end
    end

endmodule

// File: rtl/mbx_irq_enable_bank.sv
module mbx_irq_enable_bank #(
    parameter int unsigned NUM_LINES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [mbx_irq_pkg::WADDR_W-1:0]       wr_idx,
    input  logic [mbx_irq_pkg::SRC_W-1:0]         wr_data,
    output logic [NUM_LINES*mbx_irq_pkg::SRC_W-1:0] bank_flat
);
    import mbx_irq_pkg::*;

    logic [NUM_LINES-1:0][SRC_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (wr_en && (wr_idx == WADDR_W'(k))) begin
                bank_d[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_flat = bank_q;

endmodule

// File: rtl/mbx_irq_line_combine.sv
module mbx_irq_line_combine #(
    parameter int unsigned NUM_LINES = 4
) (
    input  logic [mbx_irq_pkg::SRC_W-1:0]           status,
    input  logic [NUM_LINES*mbx_irq_pkg::SRC_W-1:0] bank_flat,
    output logic [NUM_LINES-1:0]                    irq_line
);
    import mbx_irq_pkg::*;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        assign irq_line[k] = |(status & bank_flat[k*SRC_W +: SRC_W]);
    end

endmodule

// File: rtl/mbx_irq_agg.sv
module mbx_irq_agg #(
    parameter int unsigned NUM_MBOX  = 6,
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned NUM_SS    = 3,
    parameter int unsigned NUM_AS    = 2,
    parameter int unsigned NUM_DB    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MBOX-1:0]  mb_full,
    input  logic [NUM_MBOX-1:0]  mb_empty,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [9:0]           reg_waddr,
    input  logic [15:0]          reg_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [NUM_LINES-1:0] irq_line
);
    import mbx_irq_pkg::*;

    localparam logic [31:0] CAP_VALUE =
        cap_word(NUM_MBOX, NUM_SS, NUM_AS, NUM_DB, NUM_LINES);

    logic [SRC_W-1:0]           status_raw;
    logic [NUM_LINES*SRC_W-1:0] bank_flat;
    logic [WADDR_W-1:0]         bank_off;
    logic                       bank_hit;
    logic                       bank_wr;
    logic [31:0]                rd_word;
    rd_state_t                  st_d, st_q;

    mbx_irq_status_pack #(.NUM_MBOX(NUM_MBOX)) pack_i (
        .full   (mb_full),
        .empty  (mb_empty),
        .status (status_raw)
    );

    assign bank_off = reg_waddr - BANK_BASE_W;
    assign bank_hit = (reg_waddr >= BANK_BASE_W) && (bank_off < WADDR_W'(NUM_LINES));
    assign bank_wr  = reg_valid && reg_write && bank_hit;

    mbx_irq_enable_bank #(.NUM_LINES(NUM_LINES)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr),
        .wr_idx    (bank_off),
        .wr_data   (reg_wdata),
        .bank_flat (bank_flat)
    );

    mbx_irq_line_combine #(.NUM_LINES(NUM_LINES)) comb_i (
        .status    (status_raw),
        .bank_flat (bank_flat),
        .irq_line  (irq_line)
    );

    always_comb begin
        rd_word = '0;
        if (bank_hit) begin
            for (int k = 0; k < NUM_LINES; k++) begin
                if (bank_off == WADDR_W'(k)) begin
                    rd_word = {16'b0, bank_flat[k*SRC_W +: SRC_W]};
                end
            end
        end else if (reg_waddr == STATUS_W_ADR) begin
            rd_word = {16'b0, status_raw};
        end else if (reg_waddr == CAP_W_ADR) begin
            rd_word = CAP_VALUE;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = reg_valid && !reg_write;
        st_d.rdata  = (reg_valid && !reg_write) ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rvalid;
    assign rd_data  = st_q.rdata;

endmodule

// File: rtl/mbx_irq_agg_chk.sv
module mbx_irq_agg_chk #(
    parameter int unsigned NUM_MBOX  = 6,
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned NUM_SS    = 3,
    parameter int unsigned NUM_AS    = 2,
    parameter int unsigned NUM_DB    = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_MBOX-1:0]        mb_full,
    input logic [NUM_MBOX-1:0]        mb_empty,
    input logic                       reg_valid,
    input logic                       reg_write,
    input logic [9:0]                 reg_waddr,
    input logic                       rd_valid,
    input logic [31:0]                rd_data,
    input logic [NUM_LINES-1:0]       irq_line,
    input logic [NUM_LINES*16-1:0]    bank_flat
);
    import mbx_irq_pkg::*;

    localparam logic [31:0] ST_MASK = status_mask(NUM_MBOX);
    localparam logic [31:0] CAP_EXP =
        cap_word(NUM_MBOX, NUM_SS, NUM_AS, NUM_DB, NUM_LINES);

    p_read_answers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> rd_valid);

    p_no_stray_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write) |=> !rd_valid);

    p_line_needs_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_line) |-> (|{mb_full, mb_empty}));

    p_status_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(reg_waddr) == STATUS_W_ADR)) |-> ((rd_data & ~ST_MASK) == 32'h0));

    p_cap_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(reg_waddr) == CAP_W_ADR)) |-> (rd_data == CAP_EXP));

    p_banks_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && reg_write) |=> $stable(bank_flat));

endmodule

bind mbx_irq_agg mbx_irq_agg_chk #(
    .NUM_MBOX  (NUM_MBOX),
    .NUM_LINES (NUM_LINES),
    .NUM_SS    (NUM_SS),
    .NUM_AS    (NUM_AS),
    .NUM_DB    (NUM_DB)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mb_full   (mb_full),
    .mb_empty  (mb_empty),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_waddr (reg_waddr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq_line  (irq_line),
    .bank_flat (bank_flat)
);

// File: tb/mbx_irq_agg_tb_top.sv
module mbx_irq_agg_tb_top;

    localparam int NM = 6;
    localparam int NL = 4;
    localparam int NSS = 3;
    localparam int NAS = 2;
    localparam int NDB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] mb_full = '0;
    logic [NM-1:0] mb_empty = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [9:0]    reg_waddr = '0;
    logic [15:0]   reg_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [NL-1:0] irq_line;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    int model_bank [NL];

    always #2 clk = ~clk;

    mbx_irq_agg #(.NUM_MBOX(NM), .NUM_LINES(NL), .NUM_SS(NSS), .NUM_AS(NAS),
                  .NUM_DB(NDB)) dut_i (
        .clk(clk), .rst_n(rst_n), .mb_full(mb_full), .mb_empty(mb_empty),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_line(irq_line)
    );

    function automatic int model_status();
        int s = 0;
        for (int i = 0; i < NM; i++) begin
            if (mb_empty[i]) s |= (1 << i);
            if (mb_full[i])  s |= (1 << (8 + i));
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of every line against the reference (R4, R5)
    always @(negedge clk) begin
        if (running) begin
            for (int k = 0; k < NL; k++) begin
                bit exp_l;
                exp_l = (model_status() & model_bank[k]) != 0;
                chk(irq_line[k] == exp_l, $sformatf("R4 line%0d per-clock", k),
                    irq_line[k], exp_l);
            end
        end
    end

    task automatic do_write(input int waddr, input int data);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1;
        reg_waddr = 10'(waddr); reg_wdata = 16'(data);
        @(posedge clk);
        if (waddr >= 'h40 && waddr < 'h40 + NL) model_bank[waddr - 'h40] = data & 'hFFFF;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk(rd_valid == 1'b0, "R8 no rd_valid after write", rd_valid, 0);
    endtask

    task automatic do_read(input int waddr, input int exp, input string tag);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_waddr = 10'(waddr);
        @(negedge clk);
        reg_valid = 1'b0;
        chk(rd_valid == 1'b1, {tag, " rd_valid"}, rd_valid, 1);
        chk(rd_data == 32'(exp), tag, rd_data, exp);
    endtask

    task automatic set_src(input int full, input int empty);
        @(negedge clk);
        mb_full = NM'(full); mb_empty = NM'(empty);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int capx;
        for (int k = 0; k < NL; k++) model_bank[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        // R3 reset state
        chk(irq_line == '0, "R3 lines low after reset", irq_line, 0);
        chk(rd_valid == 1'b0, "R8 rd_valid low after reset", rd_valid, 0);
        for (int k = 0; k < NL; k++) do_read('h40 + k, 0, "R3 bank reset zero");

        // R1 raw status, empty half
        set_src(0, 'h3F);
        do_read('hC1, 'h003F, "R1 status empty half");
        set_src('h05, 'h3A);
        do_read('hC1, 'h053A, "R1 status mixed");
        // R2 padding zero with all sources asserted
        set_src('h3F, 'h3F);
        do_read('hC1, 'h3F3F, "R2 status padding zero");

        // R3 bank write/read, upper bits zero
        do_write('h40, 'hFFFF);
        do_read('h40, 'hFFFF, "R3 bank0 readback");
        #1 chk(irq_line[0] == 1'b1, "R4 line0 high", irq_line[0], 1);
        // R9 other banks untouched
        for (int k = 1; k < NL; k++) do_read('h40 + k, 0, "R9 other bank zero");

        // R4 same-cycle follow of sources on line2
        do_write('h42, 'h0100);
        set_src(0, 0);
        #1 chk(irq_line[2] == 1'b0, "R4 line2 low without full0", irq_line[2], 0);
        @(negedge clk);
        mb_full = NM'(1);
        #1 chk(irq_line[2] == 1'b1, "R4 line2 follows full0 same cycle", irq_line[2], 1);
        // R5 level holds
        repeat (5) begin
            @(negedge clk);
            #1 chk(irq_line[2] == 1'b1, "R5 line2 level holds", irq_line[2], 1);
        end
        do_read('h42, 'h0100, "R9 bank2 value");
        // R5 drop after enable cleared
        do_write('h42, 0);
        chk(irq_line[2] == 1'b0, "R5 line2 drops after clear", irq_line[2], 0);
        // R1 raw status unaffected by enables
        do_read('hC1, 'h0100, "R1 status raw with cleared bank");

        // R7 ignored writes
        capx = (NL << 16) | (NDB << 12) | (NAS << 8) | (NSS << 4) | NM;
        do_write('hC1, 'hFFFF);
        do_read('hC1, 'h0100, "R7 status write ignored");
        do_write('hE0, 'h1234);
        do_read('hE0, capx, "R6 capability fields");
        do_write('h40 + NL, 'hAAAA);
        do_write('h3F, 'h5555);
        for (int k = 0; k < NL; k++)
            do_read('h40 + k, model_bank[k], "R7 banks unchanged by stray writes");
        do_read('h40 + NL, 0, "R7 unmapped read zero");
        do_read('h200, 0, "R7 far unmapped read zero");

        // Different bank patterns, empty sources on line3, line1
        do_write('h43, 'h0020);
        do_write('h41, 'h2000);
        set_src('h20, 'h00);
        #1 chk(irq_line == 4'b0011, "R4 lines with full5", irq_line, 4'b0011);
        set_src('h00, 'h20);
        #1 chk(irq_line == 4'b1001, "R4 lines with empty5", irq_line, 4'b1001);
        set_src('h00, 'h00);
        #1 chk(irq_line == 4'b0000, "R4 lines idle", irq_line, 0);

        repeat (3) @(negedge clk);
        running = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule